// File: doc/BRIEF.md
# Access Flag Memory Tracker

This block keeps two sticky flag bits for every address of an emulated memory space: a read flag and a write flag. It watches the live CPU bus cycles and sets the flags as the program runs. A read or an opcode fetch sets the read flag, and a write sets the write flag. Analysis tools use the resulting picture for code coverage, for finding variables that were never touched, and for measuring stack depth. Prefetched instructions that are later discarded still mark their addresses as read, because the tracker sees only bus cycles.

The tracker can also catch a read of a location that has never been written. When this check is enabled, such a read produces a one-cycle stop pulse toward the emulation controller. The offending address is latched so the host can read it. The host can do three things without stalling the CPU side:
- clear every flag in a single cycle;
- preset the write flags over an address range, so that code and initialised data never trip the check;
- read back the flag pair of any address.

Top module: `fm_tracker`

## Requirements
- R1: After reset every read and write flag is clear, `stopPulse` and `presetBusy` are low, and `stopAddr` is zero.
- R2: A CPU cycle with `cpuValid`=1 and `cpuWrite`=0 (data read or opcode fetch) sets the read flag of `cpuAddr` and no other flag.
- R3: A CPU cycle with `cpuValid`=1 and `cpuWrite`=1 sets the write flag of `cpuAddr` and no other flag.
- R4: A CPU read with `rbwEnable`=1 at an address whose stored write flag is clear raises `stopPulse` in the next cycle only. In that same cycle `stopAddr` takes the read address.
- R5: No stop is raised for a CPU write, for a read with `rbwEnable`=0, or for a read of an address whose write flag is already set.
- R6: A `presetStart` pulse while idle, with `presetLo` <= `presetHi`, sets the write flags of every address in [`presetLo`, `presetHi`], one address per clock. `presetBusy` is high for exactly `presetHi`-`presetLo`+1 cycles, starting the cycle after the pulse. Read flags and addresses outside the range are unchanged.
- R7: A `presetStart` is ignored while `presetBusy` is high, and also when `presetLo` > `presetHi`.
- R8: A `clearAll` pulse clears every flag at the next clock edge and cancels any preset walk in progress, so `presetBusy` is low in the next cycle.
- R9: A CPU access in the same cycle as `clearAll` wins for its own address: that address keeps the flag the access sets.
- R10: `hostRdFlags` shows the flags of `hostRdAddr` one cycle after that address is presented, with bit 0 the read flag and bit 1 the write flag. Reading back never changes a flag or the stop outputs.
- R11: `stopAddr` holds its value until the next stop pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | A CPU bus cycle is present this clock |
| cpuWrite | input | 1 | 1 for write, 0 for read or opcode fetch |
| cpuAddr | input | ADDR_W | Address of the CPU bus cycle |
| rbwEnable | input | 1 | Enables the read-before-write stop check |
| stopPulse | output | 1 | One-cycle request to halt real-time emulation |
| stopAddr | output | ADDR_W | Address of the read that caused the last stop |
| clearAll | input | 1 | Clears every flag |
| presetStart | input | 1 | Starts a write-flag preset walk |
| presetLo | input | ADDR_W | First address of the preset range |
| presetHi | input | ADDR_W | Last address of the preset range |
| presetBusy | output | 1 | A preset walk is in progress |
| hostRdAddr | input | ADDR_W | Host readback address |
| hostRdFlags | output | 2 | Flags of hostRdAddr: bit 1 write, bit 0 read |

## Verification
The checker watches the port-level timing on every cycle:
- a stop is always traced to an enabled read one cycle earlier;
- the latched stop address matches that read, and stays put between stops;
- writes never stop emulation;
- a legal preset start raises busy, while an illegal start and a clear leave it low.

The bench scenarios cover what only the stored flag contents can show, by sweeping readback over the whole address space after each phase. Those phases are: mixed reads and writes, a range preset with a retrigger attempt, a clear that cancels a walk while a CPU write lands on the same cycle, and the exact busy length.

// File: rtl/fm_pkg.sv
package fm_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic clearAll;
    logic presetEn;
  } fmStrobes_t;
endpackage

// File: rtl/fm_ctrl.sv
module fm_ctrl
  import fm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearAll,
  input  logic              presetStart,
  input  logic [ADDR_W-1:0] presetLo,
  input  logic [ADDR_W-1:0] presetHi,
  output logic              presetBusy,
  output logic [ADDR_W-1:0] presetAddr,
  output fmStrobes_t        strobes
);
  logic              busyQ;
  logic [ADDR_W-1:0] ptrQ;
  logic [ADDR_W-1:0] lastQ;
  logic              startOk;

  assign startOk = presetStart && !busyQ && (presetLo <= presetHi);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      ptrQ  <= '0;
      lastQ <= '0;
    end else if (clearAll) begin
      busyQ <= 1'b0;
    end else if (busyQ) begin
      if (ptrQ == lastQ) busyQ <= 1'b0;
      else               ptrQ  <= ptrQ + 1'b1;
    end else if (startOk) begin
      busyQ <= 1'b1;
      ptrQ  <= presetLo;
      lastQ <= presetHi;
    end
  end

  always_comb begin
    strobes.clearAll = clearAll;
    strobes.presetEn = busyQ && !clearAll;
  end

  assign presetBusy = busyQ;
  assign presetAddr = ptrQ;
endmodule

// File: rtl/fm_data.sv
module fm_data
  import fm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fmStrobes_t        strobes,
  input  logic [ADDR_W-1:0] presetAddr,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              rbwEnable,
  input  logic [ADDR_W-1:0] hostRdAddr,
  output logic [1:0]        hostRdFlags,
  output logic              stopPulse,
  output logic [ADDR_W-1:0] stopAddr
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] rdFlag;
  logic [DEPTH-1:0] wrFlag;
  logic             rbwHit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic cpuHere;
    logic presetHere;
    assign cpuHere    = cpuValid && (cpuAddr == ADDR_W'(i));
    assign presetHere = strobes.presetEn && (presetAddr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdFlag[i] <= 1'b0;
        wrFlag[i] <= 1'b0;
      end else begin
        // CPU-side set has priority over a clear on the same cycle
        if (cpuHere && !cpuWrite)       rdFlag[i] <= 1'b1;
        else if (strobes.clearAll)      rdFlag[i] <= 1'b0;

        if ((cpuHere && cpuWrite) || presetHere) wrFlag[i] <= 1'b1;
        else if (strobes.clearAll)               wrFlag[i] <= 1'b0;
      end
    end
  end

  // Checked against the stored state before this cycle's updates
  assign rbwHit = cpuValid && !cpuWrite && rbwEnable && !wrFlag[cpuAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopPulse   <= 1'b0;
      stopAddr    <= '0;
      hostRdFlags <= 2'b00;
    end else begin
      stopPulse   <= rbwHit;
      if (rbwHit) stopAddr <= cpuAddr;
      hostRdFlags <= {wrFlag[hostRdAddr], rdFlag[hostRdAddr]};
    end
  end
endmodule

// File: rtl/fm_tracker.sv
module fm_tracker
  import fm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              rbwEnable,
  output logic              stopPulse,
  output logic [ADDR_W-1:0] stopAddr,
  input  logic              clearAll,
  input  logic              presetStart,
  input  logic [ADDR_W-1:0] presetLo,
  input  logic [ADDR_W-1:0] presetHi,
  output logic              presetBusy,
  input  logic [ADDR_W-1:0] hostRdAddr,
  output logic [1:0]        hostRdFlags
);
  fmStrobes_t        strobes;
  logic [ADDR_W-1:0] presetAddr;

  fm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .clearAll    (clearAll),
    .presetStart (presetStart),
    .presetLo    (presetLo),
    .presetHi    (presetHi),
    .presetBusy  (presetBusy),
    .presetAddr  (presetAddr),
    .strobes     (strobes)
  );

  fm_data #(.ADDR_W(ADDR_W)) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .presetAddr  (presetAddr),
    .cpuValid    (cpuValid),
    .cpuWrite    (cpuWrite),
    .cpuAddr     (cpuAddr),
    .rbwEnable   (rbwEnable),
    .hostRdAddr  (hostRdAddr),
    .hostRdFlags (hostRdFlags),
    .stopPulse   (stopPulse),
    .stopAddr    (stopAddr)
  );
endmodule

// File: rtl/fm_tracker_chk.sv
module fm_tracker_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuValid,
  input logic              cpuWrite,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              rbwEnable,
  input logic              stopPulse,
  input logic [ADDR_W-1:0] stopAddr,
  input logic              clearAll,
  input logic              presetStart,
  input logic [ADDR_W-1:0] presetLo,
  input logic [ADDR_W-1:0] presetHi,
  input logic              presetBusy,
  input logic [ADDR_W-1:0] hostRdAddr,
  input logic [1:0]        hostRdFlags
);
  p_stop_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    stopPulse |-> $past(cpuValid && !cpuWrite && rbwEnable));

  p_stop_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    stopPulse |-> (stopAddr == $past(cpuAddr)));

  p_write_no_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && cpuWrite) |=> !stopPulse);

  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !stopPulse |-> $stable(stopAddr));

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!presetBusy && presetStart && !clearAll && (presetLo <= presetHi)) |=> presetBusy);

  p_bad_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!presetBusy && presetStart && (presetLo > presetHi)) |=> !presetBusy);

  p_clear_cancel_r8: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> !presetBusy);
endmodule

bind fm_tracker fm_tracker_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_fm_tracker.sv
module sim_fm_tracker;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cpuValid, cpuWrite, rbwEnable;
  logic [AW-1:0] cpuAddr;
  logic          stopPulse;
  logic [AW-1:0] stopAddr;
  logic          clearAll, presetStart, presetBusy;
  logic [AW-1:0] presetLo, presetHi, hostRdAddr;
  logic [1:0]    hostRdFlags;

  int nTests = 0;
  int nFail  = 0;
  bit mRd [N];
  bit mWr [N];
  int lastStop = 0;

  always #5 clk = ~clk;

  fm_tracker #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .rbwEnable(rbwEnable), .stopPulse(stopPulse),
    .stopAddr(stopAddr), .clearAll(clearAll), .presetStart(presetStart),
    .presetLo(presetLo), .presetHi(presetHi), .presetBusy(presetBusy),
    .hostRdAddr(hostRdAddr), .hostRdFlags(hostRdFlags)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < N; a++) begin
      hostRdAddr = AW'(a);
      @(negedge clk);
      chk(hostRdFlags == {mWr[a], mRd[a]}, tag, int'(hostRdFlags),
          int'({mWr[a], mRd[a]}));
    end
  endtask

  task automatic cpuOp(input int addr, input bit wr, input bit rbw);
    bit expStop;
    expStop   = !wr && rbw && !mWr[addr];
    cpuValid  = 1'b1; cpuWrite = wr; cpuAddr = AW'(addr); rbwEnable = rbw;
    if (wr) mWr[addr] = 1'b1; else mRd[addr] = 1'b1;
    @(negedge clk);
    cpuValid = 1'b0;
    chk(stopPulse == expStop, expStop ? "R4 stop pulse" : "R5 no stop",
        int'(stopPulse), int'(expStop));
    if (expStop) lastStop = addr;
    chk(int'(stopAddr) == lastStop, expStop ? "R4 stop address" : "R11 address held",
        int'(stopAddr), lastStop);
  endtask

  task automatic modelClear();
    for (int a = 0; a < N; a++) begin mRd[a] = 1'b0; mWr[a] = 1'b0; end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int cnt;
    rstN = 1'b0; cpuValid = 1'b0; cpuWrite = 1'b0; cpuAddr = '0; rbwEnable = 1'b0;
    clearAll = 1'b0; presetStart = 1'b0; presetLo = '0; presetHi = '0; hostRdAddr = '0;
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!stopPulse, "R1 stop low", int'(stopPulse), 0);
    chk(!presetBusy, "R1 busy low", int'(presetBusy), 0);
    chk(stopAddr == '0, "R1 stop address zero", int'(stopAddr), 0);
    sweep("R1 flags clear");

    // R2 reads, R3 writes, check disabled (R5)
    for (int a = 0; a < N; a += 2) cpuOp(a, 1'b0, 1'b0);
    for (int a = 0; a < N; a += 3) cpuOp(a, 1'b1, 1'b0);
    sweep("R2 R3 R10 flag readback");

    // R4 enabled sweep: stop only where no write happened, then idle cycle (R11)
    for (int a = 0; a < N; a++) begin
      cpuOp(a, 1'b0, 1'b1);
      @(negedge clk);
      chk(!stopPulse, "R4 single cycle pulse", int'(stopPulse), 0);
      chk(int'(stopAddr) == lastStop, "R11 address held idle", int'(stopAddr), lastStop);
    end
    sweep("R10 readback unchanged");

    // R8 clear
    clearAll = 1'b1; @(negedge clk); clearAll = 1'b0;
    modelClear();
    sweep("R8 cleared");

    // R6 preset 3..9, with a retrigger attempt (R7)
    presetLo = 4'd3; presetHi = 4'd9; presetStart = 1'b1;
    @(negedge clk);
    presetStart = 1'b0;
    cnt = 0;
    while (presetBusy && cnt < 40) begin
      cnt++;
      presetStart = (cnt == 2);
      if (cnt == 2) begin presetLo = 4'd0; presetHi = 4'd15; end
      @(negedge clk);
    end
    presetStart = 1'b0;
    chk(cnt == 7, "R6 R7 busy length", cnt, 7);
    for (int a = 3; a <= 9; a++) mWr[a] = 1'b1;
    sweep("R6 R7 preset range");

    // R7 reversed range
    presetLo = 4'd10; presetHi = 4'd4; presetStart = 1'b1;
    @(negedge clk);
    presetStart = 1'b0;
    chk(!presetBusy, "R7 reversed range ignored", int'(presetBusy), 0);
    sweep("R7 flags unchanged");

    // R5 reads inside the preset range never stop
    for (int a = 3; a <= 9; a++) cpuOp(a, 1'b0, 1'b1);

    // R8 clear cancels a walk; R9 CPU write on same cycle survives
    presetLo = 4'd0; presetHi = 4'd15; presetStart = 1'b1;
    @(negedge clk);
    presetStart = 1'b0;
    repeat (2) @(negedge clk);
    clearAll = 1'b1; cpuValid = 1'b1; cpuWrite = 1'b1; cpuAddr = 4'd12; rbwEnable = 1'b0;
    @(negedge clk);
    clearAll = 1'b0; cpuValid = 1'b0;
    chk(!presetBusy, "R8 walk cancelled", int'(presetBusy), 0);
    repeat (3) @(negedge clk);
    chk(!presetBusy, "R8 walk stays cancelled", int'(presetBusy), 0);
    modelClear();
    mWr[12] = 1'b1;
    sweep("R9 write wins over clear");

    // R9 read on the same cycle as clear
    clearAll = 1'b1; cpuValid = 1'b1; cpuWrite = 1'b0; cpuAddr = 4'd5;
    @(negedge clk);
    clearAll = 1'b0; cpuValid = 1'b0;
    modelClear();
    mRd[5] = 1'b1;
    sweep("R9 read wins over clear");

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule